// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a watchdog timer that requests a system reset when software fails to service it in time. It also requests a reset when software writes a corrupt value to its key register. Software first puts the timer in watchdog mode and releases both counter halves through a configuration register, and it sets a 64-bit timeout period. It then arms the watchdog with two key writes in a fixed order. The first key moves the unit from the off state to a pending state. The second key moves it from pending to armed.

While armed, an internal 64-bit counter advances on every clock. Writing the first key and then the second key services the watchdog and restarts the count from zero. If the count reaches the period, or if the key field receives a value other than the two keys, the reset request rises one cycle later and stays high until system reset. Once the unit leaves the off state, the configuration and the period are locked. Software cannot disarm an armed watchdog.

Top module: `wdog_key_ctrl`

## Requirements
- R1: After reset, `wd_state` is 0 (off), `rst_req` is 0 and `count` is 0.
- R2: A write to address 3 with bits 31:16 equal to 0xA5C6 and bit 14 set moves the state from 0 to 1 (pending). This happens only when the configuration register (address 0) holds the value 2 in bits 3:2 and the value 2'b11 in bits 1:0. If that configuration is missing, or bit 14 is clear, the write leaves the state at 0.
- R3: In state 1, a write to address 3 with key 0xDA7E and bit 14 set moves the state to 2 (armed), with `count` at 0. The armed state is reachable only from state 1.
- R4: In state 2, a key write of 0xA5C6 followed later by a key write of 0xDA7E sets `count` to 0 on the second write. A write of 0xDA7E that does not follow 0xA5C6 does not clear `count`.
- R5: In state 2, a write to address 3 whose key field is neither 0xA5C6 nor 0xDA7E (for example 0x00004000) raises `rst_req` on the next clock edge.
- R6: In state 2, `count` rises by one per clock starting from 0. On the edge after `count` equals the period, `rst_req` rises and `count` freezes.
- R7: State 2 persists until `rst_n` is asserted. Key writes with bit 14 clear do not disarm it.
- R8: Once `rst_req` is 1, it stays 1 until `rst_n` is asserted.
- R9: In states 0 and 1, key writes with a wrong key (or with the other valid key) leave the state unchanged.
- R10: The configuration register (address 0) and the period halves (address 1 holds the low half, address 2 the high half) take writes only in state 0. In other states these writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0 config, 1 period low, 2 period high, 3 key |
| wr_data | input | 32 | Write data |
| wd_state | output | 2 | 0 off, 1 pending, 2 armed |
| count | output | 64 | Watchdog counter value |
| rst_req | output | 1 | Sticky reset request |

## Verification
The hardest situation to reach is the collision between a service write and the timeout. It needs an armed unit, a half-completed key pair and a second key that lands exactly on the cycle where the count equals the period. Directed sequences cover the arming order, key rejection and the config and period lock. A seeded random phase then mixes config, period and key writes with small periods. Both phases are checked cycle by cycle against a bench model, so they repeatedly hit timeouts near service pairs and bad keys near the edge.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_PEND  = 2'd1,
    WD_ARMED = 2'd2
  } wd_state_e;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;
  localparam int          KEY_LSB    = 16;
  localparam int          EN_POS     = 14;
  localparam int          MODE_LSB   = 2;
  localparam int          REL_LSB    = 0;
  localparam logic [1:0]  MODE_WDOG  = 2'd2;

  function automatic logic [15:0] key_of(input logic [31:0] d);
    return d[KEY_LSB +: 16];
  endfunction

  function automatic logic en_of(input logic [31:0] d);
    return d[EN_POS];
  endfunction

  function automatic logic key_ok(input logic [15:0] k);
    return (k == KEY_FIRST) || (k == KEY_SECOND);
  endfunction
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int A_CFG  = 0,
  parameter int A_PLO  = 1,
  parameter int A_PHI  = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock,
  output logic              cfg_ok,
  output logic [CNT_W-1:0]  period
);
  import wdk_pkg::*;

  logic [1:0]       mode_q;
  logic [1:0]       rel_q;
  logic [CNT_W-1:0] prd_q;
  logic             wr_open;

  assign wr_open = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rel_q  <= '0;
      prd_q  <= '0;
    end else if (wr_open) begin
      if (wr_addr == ADDR_W'(A_CFG)) begin
        mode_q <= wr_data[MODE_LSB +: 2];
        rel_q  <= wr_data[REL_LSB +: 2];
      end
      if (wr_addr == ADDR_W'(A_PLO)) prd_q[DATA_W-1:0]     <= wr_data;
      if (wr_addr == ADDR_W'(A_PHI)) prd_q[CNT_W-1:DATA_W] <= wr_data;
    end
  end

  assign cfg_ok = (mode_q == MODE_WDOG) && (rel_q == 2'b11);
  assign period = prd_q;
endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_wr,
  input  logic [15:0]        key,
  input  logic               en_bit,
  input  logic               cfg_ok,
  input  logic               timeout_evt,
  output wdk_pkg::wd_state_e state,
  output logic               bite,
  output logic               svc_evt,
  output logic               bad_key_evt
);
  import wdk_pkg::*;

  wd_state_e state_q, state_d;
  logic      arm_q;
  logic      bite_q;
  logic      live_wr;

  assign live_wr     = key_wr && (state_q == WD_ARMED) && !bite_q;
  assign bad_key_evt = live_wr && !key_ok(key);
  assign svc_evt     = live_wr && (key == KEY_SECOND) && arm_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_OFF:  if (key_wr && cfg_ok && en_bit && key == KEY_FIRST)  state_d = WD_PEND;
      WD_PEND: if (key_wr && cfg_ok && en_bit && key == KEY_SECOND) state_d = WD_ARMED;
      default: state_d = WD_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_OFF;
      arm_q   <= 1'b0;
      bite_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (live_wr) arm_q <= (key == KEY_FIRST);
      if (bad_key_evt || timeout_evt) bite_q <= 1'b1;
    end
  end

  assign state = state_q;
  assign bite  = bite_q;
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             timeout_evt
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign timeout_evt = run && (cnt_q == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (run) begin
      if (timeout_evt)      cnt_q <= cnt_q;
      else if (clear)       cnt_q <= '0;
      else                  cnt_q <= bump(cnt_q);
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_key_ctrl.sv
module wdog_key_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int A_CFG  = 0,
  parameter int A_PLO  = 1,
  parameter int A_PHI  = 2,
  parameter int A_KEY  = 3,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        wd_state,
  output logic [CNT_W-1:0]  count,
  output logic              rst_req
);
  import wdk_pkg::*;

  wd_state_e        state;
  logic             cfg_ok;
  logic [CNT_W-1:0] period;
  logic             key_wr;
  logic             bite;
  logic             svc_evt;
  logic             bad_key_evt;
  logic             timeout_evt;
  logic             run;

  assign key_wr = wr_en && (wr_addr == ADDR_W'(A_KEY));
  assign run    = (state == WD_ARMED) && !bite;

  wdk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_CFG(A_CFG), .A_PLO(A_PLO), .A_PHI(A_PHI)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock(state != WD_OFF), .cfg_ok(cfg_ok), .period(period)
  );

  wdk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key(key_of(wr_data)),
    .en_bit(en_of(wr_data)), .cfg_ok(cfg_ok), .timeout_evt(timeout_evt),
    .state(state), .bite(bite), .svc_evt(svc_evt), .bad_key_evt(bad_key_evt)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(svc_evt), .period(period),
    .count(count), .timeout_evt(timeout_evt)
  );

  assign wd_state = state;
  assign rst_req  = bite;
endmodule

// File: rtl/wdk_chk.sv
module wdk_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       wd_state,
  input logic [CNT_W-1:0] count,
  input logic             rst_req,
  input logic             bad_key_evt,
  input logic             timeout_evt,
  input logic             svc_evt
);
  AST_ENTRY_VIA_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_state == 2'd0) |=> (wd_state != 2'd2)); // R3

  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_evt && !timeout_evt) |=> (count == '0)); // R4

  AST_BADKEY_BITES: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key_evt |=> rst_req); // R5

  AST_TIMEOUT_BITES: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> rst_req); // R6

  AST_FROZEN_AFTER_BITE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> $stable(count)); // R6

  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_state == 2'd2) |=> (wd_state == 2'd2)); // R7

  AST_BITE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R8
endmodule

bind wdog_key_ctrl wdk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_state(wd_state), .count(count), .rst_req(rst_req),
  .bad_key_evt(bad_key_evt), .timeout_evt(timeout_evt), .svc_evt(svc_evt)
);

// File: tb/wdog_key_ctrl_tb.sv
`timescale 1ns/1ps
module wdog_key_ctrl_tb;
  localparam logic [15:0] K1 = 16'hA5C6;
  localparam logic [15:0] K2 = 16'hDA7E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wd_state;
  logic [63:0] count;
  logic        rst_req;

  int checks = 0;
  int errors = 0;

  logic [1:0]  m_st;
  logic [63:0] m_cnt, m_prd;
  logic [3:0]  m_cfg;
  logic        m_bite, m_arm;

  always #4 clk = ~clk;

  wdog_key_ctrl u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wd_state(wd_state), .count(count), .rst_req(rst_req));

  function automatic logic [31:0] keyw(input logic [15:0] k, input logic e);
    return {k, 1'b0, e, 14'd0};
  endfunction

  function automatic logic cfg_good(input logic [3:0] c);
    return (c[3:2] == 2'd2) && (c[1:0] == 2'b11);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_prd = 0; m_cfg = 0; m_bite = 0; m_arm = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic step(input logic en, input logic [3:0] a, input logic [31:0] d);
    logic        kw, e, hit, live, bad, svc;
    logic [15:0] k;
    logic [1:0]  n_st;
    wr_en = en; wr_addr = a; wr_data = d;
    kw   = en && (a == 4'd3);
    k    = d[31:16];
    e    = d[14];
    hit  = (m_st == 2) && !m_bite && (m_cnt == m_prd);
    live = kw && (m_st == 2) && !m_bite;
    bad  = live && (k != K1) && (k != K2);
    svc  = live && (k == K2) && m_arm;
    n_st = m_st;
    if (m_st == 0 && kw && cfg_good(m_cfg) && e && k == K1) n_st = 1;
    if (m_st == 1 && kw && cfg_good(m_cfg) && e && k == K2) n_st = 2;
    @(negedge clk);
    wr_en = 1'b0;
    if (m_st == 2 && !m_bite && !hit) m_cnt = svc ? 64'd0 : m_cnt + 64'd1;
    if (live) m_arm = (k == K1);
    if (bad || hit) m_bite = 1'b1;
    if (en && m_st == 0) begin
      if (a == 4'd0) m_cfg = d[3:0];
      if (a == 4'd1) m_prd[31:0] = d;
      if (a == 4'd2) m_prd[63:32] = d;
    end
    m_st = n_st;
    chk(wd_state == m_st, "R2/R3/R7/R9 state", 64'(wd_state), 64'(m_st));
    chk(count == m_cnt, "R4/R6 count", count, m_cnt);
    chk(rst_req == m_bite, "R5/R6/R8 rst_req", 64'(rst_req), 64'(m_bite));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 32'd0);
  endtask

  task automatic setup_armed(input logic [31:0] prd);
    step(1'b1, 4'd0, 32'h0000_000B);
    step(1'b1, 4'd1, prd);
    step(1'b1, 4'd2, 32'd0);
    step(1'b1, 4'd3, keyw(K1, 1'b1));
    step(1'b1, 4'd3, keyw(K2, 1'b1));
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog R1..R10 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(wd_state == 2'd0 && !rst_req && count == 64'd0, "R1 reset", {count[61:0], wd_state}, 64'd0);

    // R2: key without config is ignored; bit 14 clear is ignored
    step(1'b1, 4'd3, keyw(K1, 1'b1));
    chk(wd_state == 2'd0, "R2 no-config", 64'(wd_state), 64'd0);
    step(1'b1, 4'd0, 32'h0000_000B);
    step(1'b1, 4'd1, 32'd20);
    step(1'b1, 4'd3, keyw(K1, 1'b0));
    chk(wd_state == 2'd0, "R2 bit14-clear", 64'(wd_state), 64'd0);
    // R3, R9: second key first, and wrong key, ignored when off
    step(1'b1, 4'd3, keyw(K2, 1'b1));
    chk(wd_state == 2'd0, "R3 skip-pending", 64'(wd_state), 64'd0);
    step(1'b1, 4'd3, keyw(16'h1234, 1'b1));
    chk(wd_state == 2'd0, "R9 off bad key", 64'(wd_state), 64'd0);
    step(1'b1, 4'd3, keyw(K1, 1'b1));
    chk(wd_state == 2'd1, "R2 pending", 64'(wd_state), 64'd1);
    step(1'b1, 4'd3, 32'h0000_4000);
    chk(wd_state == 2'd1 && !rst_req, "R9 pending bad key", 64'(wd_state), 64'd1);
    // R10: period write ignored once pending
    step(1'b1, 4'd1, 32'd5);
    step(1'b1, 4'd3, keyw(K2, 1'b1));
    chk(wd_state == 2'd2 && count == 64'd0, "R3 armed", 64'(wd_state), 64'd2);

    idle(8);
    chk(count == 64'd8, "R6 increments", count, 64'd8);
    step(1'b1, 4'd0, 32'd0);
    chk(!rst_req && count == 64'd9, "R10 locked period/config", count, 64'd9);
    step(1'b1, 4'd3, keyw(K2, 1'b0));
    chk(wd_state == 2'd2 && count == 64'd10, "R4 lone second key / R7", count, 64'd10);
    step(1'b1, 4'd3, keyw(K1, 1'b0));
    step(1'b1, 4'd3, keyw(K2, 1'b0));
    chk(count == 64'd0 && wd_state == 2'd2, "R4 service clears / R7 bit14 clear", count, 64'd0);

    while (!rst_req && checks < 2000) step(1'b0, 4'd0, 32'd0);
    chk(rst_req && count == 64'd20, "R6 timeout at period", count, 64'd20);
    idle(5);
    chk(rst_req && count == 64'd20, "R8 sticky / R6 frozen", count, 64'd20);

    do_reset();
    chk(!rst_req && wd_state == 2'd0, "R1 reset clears bite", 64'(rst_req), 64'd0);
    setup_armed(32'd1000);
    idle(3);
    step(1'b1, 4'd3, 32'h0000_4000);
    chk(rst_req == 1'b1, "R5 bad key bites", 64'(rst_req), 64'd1);
    idle(3);
    chk(rst_req && wd_state == 2'd2, "R8 sticky after bad key", 64'(rst_req), 64'd1);

    // Corner: service second key on the cycle count equals period
    do_reset();
    setup_armed(32'd4);
    idle(3);
    step(1'b1, 4'd3, keyw(K1, 1'b1));
    step(1'b1, 4'd3, keyw(K2, 1'b1));
    chk(rst_req && count == 64'd4, "R6 timeout wins over service", count, 64'd4);

    // Random phase
    void'($urandom(32'd17));
    for (int r = 0; r < 8; r++) begin
      do_reset();
      if (r[0]) setup_armed($urandom % 48);
      for (int i = 0; i < 150; i++) begin
        int unsigned op;
        op = $urandom % 10;
        case (op)
          0: step(1'b1, 4'd0, ($urandom % 2) ? 32'h0000_000B : $urandom);
          1: step(1'b1, 4'd1, $urandom % 48);
          2: step(1'b1, 4'd2, ($urandom % 4 == 0) ? $urandom : 32'd0);
          3, 4: step(1'b1, 4'd3, keyw(K1, ($urandom % 4) != 0));
          5, 6: step(1'b1, 4'd3, keyw(K2, ($urandom % 4) != 0));
          7: step(1'b1, 4'd3, ($urandom % 3 == 0) ? $urandom : keyw(K1, 1'b1));
          default: step(1'b0, 4'($urandom % 4), $urandom);
        endcase
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule